// File: doc/BRIEF.md
# Ethernet Status LED Controller

This block drives two network status indicator pins from a sampled view of the link: link-up, a two-bit speed code, duplex, collision, raw traffic, traffic that passed the MAC's address filters, a single-lane bus flag and a transmit-paused flag. Each pin has an 8-bit configuration field. A 4-bit mode in that field picks the condition that lights the LED. A blink enable makes the lit state flash, and an invert bit sets whether the pin is driven high or low when lit.

The two fields share one 16-bit configuration word. LED1 is in the upper byte and LED0 is in the lower byte. The word takes a parameter default at reset and can be replaced whole through a one-cycle write strobe. Collision and traffic inputs are single-cycle pulses. Each one is stretched to a fixed visible width. Blink timing and stretch width come from a clock-frequency parameter.

Top module: `netled_ctrl`

## Requirements
- R1: At reset the configuration word equals RST_WORD, which defaults to 16'h0604: LED1 mode 0110 and LED0 mode 0100, no blink, invert 0. Each pin then reads 1 (unlit, active low) while the link is down. With a link up at speed code 01 and no traffic, both pins read 0.
- R2: Each byte is laid out as {blink[7], invert[6], rate[5], reserved[4], mode[3:0]}. The speed code is 00 for 10 Mb/s, 01 for 100 Mb/s, 10 for 1000 Mb/s, and 11 for no speed. The speed modes light only while link_up is 1. Mode 0000 lights on 10 or 1000. Mode 0001 lights on 100 or 1000. Mode 0010 lights at any code, including 11. Mode 0101 lights on 10 only, mode 0110 on 100 only, and mode 0111 on 1000 only.
- R3: Mode 0100 lights while link_up is 1 and stretched raw traffic is absent. It goes dark while stretched traffic is present or the link is down.
- R4: Mode 0011 lights on link plus stretched filtered traffic, and a raw-traffic pulse alone does not light it. Mode 1011 lights on link plus stretched raw traffic.
- R5: Mode 1001 follows full_duplex, mode 1010 follows stretched collision, mode 1100 follows bus_x1, and mode 1101 follows tx_paused.
- R6: Mode 1110 is always lit. Modes 1111 and 1000 are never lit, whatever the inputs are.
- R7: Invert 0 drives a lit LED as 0 and an unlit LED as 1. Invert 1 drives a lit LED as 1 and an unlit LED as 0.
- R8: A single-cycle collision or traffic pulse keeps its stretched condition asserted for exactly STRETCH_MS×CLK_HZ/1000 clock cycles at the pin.
- R9: When blink is enabled, a lit LED toggles every SLOW_MS ms (200 by default) if LED0's rate bit (bit 5) is 0, and every FAST_MS ms (83 by default) if that bit is 1. Both LEDs use this rate, and LED1's own rate bit (bit 13) is ignored.
- R10: A blinking LED whose condition is inactive rests at its unlit level and does not toggle.
- R11: When cfg_we is 1 at a clock edge, cfg_wdata replaces the configuration word, and the pins show the new configuration from the following edge. Reserved bits 4 and 12 have no effect.
- R12: A change on a status input reaches the pin at the first clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | New configuration word (LED1 upper byte, LED0 lower byte) |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Speed code: 00=10, 01=100, 10=1000, 11=none |
| full_duplex | input | 1 | Link is full duplex |
| collision | input | 1 | Collision pulse |
| act_any | input | 1 | Transmit or receive traffic pulse |
| act_filt | input | 1 | Traffic-passed-MAC-filter pulse |
| bus_x1 | input | 1 | Host bus is a single lane |
| tx_paused | input | 1 | Transmitter held by flow control |
| led_pin | output | 2 | LED drive pins, bit 1 = LED1, bit 0 = LED0 |

## Verification
The bench sweeps every speed code against every speed mode. This catches a decoder that swaps the "10 or 1000" and "100 or 1000" pairs, or that lights a speed mode while the link is down. It measures the exact stretch width and the blink half-periods in cycles, so an off-by-one counter or a swapped rate shows up as a wrong count. It sets LED1's rate bit against LED0's, and a design that honoured LED1's own bit would blink at the wrong period. It also holds a blinking LED on an inactive condition, writes set reserved bits, and checks the one- and two-edge latencies of inputs and configuration writes.

// File: rtl/netled_pkg.sv
package netled_pkg;

  typedef struct packed {
    logic       blink;
    logic       inv;
    logic       rate;
    logic       rsvd;
    logic [3:0] mode;
  } led_cfg_t;

  typedef struct packed {
    logic       up;
    logic [1:0] spd;
    logic       fdx;
    logic       col;
    logic       act;
    logic       fact;
    logic       x1;
    logic       paused;
  } link_view_t;

  typedef enum logic [3:0] {
    M_L10_1G  = 4'h0,
    M_L100_1G = 4'h1,
    M_LINK    = 4'h2,
    M_FACT    = 4'h3,
    M_LINKACT = 4'h4,
    M_L10     = 4'h5,
    M_L100    = 4'h6,
    M_L1G     = 4'h7,
    M_RSVD    = 4'h8,
    M_FDX     = 4'h9,
    M_COL     = 4'hA,
    M_ACT     = 4'hB,
    M_X1      = 4'hC,
    M_PAUSE   = 4'hD,
    M_ON      = 4'hE,
    M_OFF     = 4'hF
  } led_mode_e;

  // Decide whether the selected condition is currently true.
  function automatic logic mode_hit(logic [3:0] mode, link_view_t s);
    logic s10, s100, s1g, hit;
    s10  = s.up && (s.spd == 2'd0);
    s100 = s.up && (s.spd == 2'd1);
    s1g  = s.up && (s.spd == 2'd2);
    case (led_mode_e'(mode))
      M_L10_1G:  hit = s10 | s1g;
      M_L100_1G: hit = s100 | s1g;
      M_LINK:    hit = s.up;
      M_FACT:    hit = s.up & s.fact;
      M_LINKACT: hit = s.up & ~s.act;
      M_L10:     hit = s10;
      M_L100:    hit = s100;
      M_L1G:     hit = s1g;
      M_FDX:     hit = s.fdx;
      M_COL:     hit = s.col;
      M_ACT:     hit = s.up & s.act;
      M_X1:      hit = s.x1;
      M_PAUSE:   hit = s.paused;
      M_ON:      hit = 1'b1;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Convert condition, blink phase and polarity into the pin level.
  function automatic logic pin_level(led_cfg_t c, logic ind, logic phase);
    logic lit;
    lit = ind & (~c.blink | phase);
    return c.inv ? lit : ~lit;
  endfunction

endpackage

// File: rtl/netled_tick.sv
module netled_tick #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/netled_blinker.sv
module netled_blinker #(
  parameter int HALF_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase
);
  localparam int CW = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (tick) begin
      if (wrap) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/netled_stretch.sv
module netled_stretch #(
  parameter int CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic held
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign held = pulse | (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (pulse)      cnt <= CW'(CYC - 1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/netled_ctrl.sv
module netled_ctrl
  import netled_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          SLOW_MS    = 200,
  parameter int          FAST_MS    = 83,
  parameter int          STRETCH_MS = 10,
  parameter logic [15:0] RST_WORD   = 16'h0604
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        link_up,
  input  logic [1:0]  link_speed,
  input  logic        full_duplex,
  input  logic        collision,
  input  logic        act_any,
  input  logic        act_filt,
  input  logic        bus_x1,
  input  logic        tx_paused,
  output logic [1:0]  led_pin
);
  localparam int DIV_RAW     = CLK_HZ / 1000;
  localparam int DIV         = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int STRETCH_CYC = (STRETCH_MS * DIV < 1) ? 1 : STRETCH_MS * DIV;
  localparam int NLED        = 2;
  localparam int NPULSE      = 3;

  logic [15:0]       cfg_q;
  logic              ms_tick;
  logic [1:0]        blink_ph;
  logic              rate_ph;
  logic [NPULSE-1:0] pulse_in;
  logic [NPULSE-1:0] pulse_str;
  logic [NLED-1:0]   ind;
  logic [NLED-1:0]   led_q;
  link_view_t        view;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= RST_WORD;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  netled_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ms_tick)
  );

  for (genvar r = 0; r < 2; r++) begin : g_rate
    localparam int HMS = (r == 0) ? SLOW_MS : FAST_MS;
    netled_blinker #(.HALF_MS(HMS)) u_blink (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ms_tick),
      .phase(blink_ph[r])
    );
  end

  // One rate for both LEDs, chosen by LED0's rate bit.
  assign rate_ph = cfg_q[5] ? blink_ph[1] : blink_ph[0];

  assign pulse_in = {collision, act_any, act_filt};

  for (genvar p = 0; p < NPULSE; p++) begin : g_str
    netled_stretch #(.CYC(STRETCH_CYC)) u_str (
      .clk  (clk),
      .rst_n(rst_n),
      .pulse(pulse_in[p]),
      .held (pulse_str[p])
    );
  end

  always_comb begin
    view.up     = link_up;
    view.spd    = link_speed;
    view.fdx    = full_duplex;
    view.col    = pulse_str[2];
    view.act    = pulse_str[1];
    view.fact   = pulse_str[0];
    view.x1     = bus_x1;
    view.paused = tx_paused;
  end

  for (genvar i = 0; i < NLED; i++) begin : g_led
    led_cfg_t lc;
    assign lc     = led_cfg_t'(cfg_q[8*i +: 8]);
    assign ind[i] = mode_hit(lc.mode, view);

    always_ff @(posedge clk) begin
      if (!rst_n) led_q[i] <= ~RST_WORD[8*i + 6];
      else        led_q[i] <= pin_level(lc, ind[i], rate_ph);
    end
  end

  assign led_pin = led_q;
endmodule

// File: rtl/netled_chk.sv
module netled_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_q,
  input logic        ms_tick,
  input logic [1:0]  blink_ph,
  input logic        col_in,
  input logic        col_str,
  input logic [1:0]  ind,
  input logic [1:0]  led_pin
);
  // R9: blink phases only move on a millisecond tick
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(blink_ph));

  // R8: a collision pulse is still held on the following cycle
  p_col_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_in |=> col_str);

  // R10: inactive condition leaves LED0 at its unlit level
  p_rest_led0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ind[0] |=> (led_pin[0] == ~$past(cfg_q[6])));

  // R10: inactive condition leaves LED1 at its unlit level
  p_rest_led1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ind[1] |=> (led_pin[1] == ~$past(cfg_q[14])));

  // R6: steady always-on mode drives LED0 at its lit level
  p_const_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[3:0] == 4'hE && !cfg_q[7]) |=> (led_pin[0] == $past(cfg_q[6])));

  // R11: a write strobe loads the configuration word
  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));
endmodule

bind netled_ctrl netled_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_q    (cfg_q),
  .ms_tick  (ms_tick),
  .blink_ph (blink_ph),
  .col_in   (collision),
  .col_str  (pulse_str[2]),
  .ind      (ind),
  .led_pin  (led_pin)
);

// File: tb/sim_netled_ctrl.sv
`timescale 1ns/1ps
module sim_netled_ctrl;
  localparam int CLK_HZ = 4000;
  localparam int DIV    = CLK_HZ / 1000;
  localparam int SLOW_H = 200 * DIV;
  localparam int FAST_H = 83 * DIV;
  localparam int STR_N  = 10 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        link_up = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic        full_duplex = 1'b0;
  logic        collision = 1'b0;
  logic        act_any = 1'b0;
  logic        act_filt = 1'b0;
  logic        bus_x1 = 1'b0;
  logic        tx_paused = 1'b0;
  logic [1:0]  led_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  netled_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
    .collision(collision), .act_any(act_any), .act_filt(act_filt),
    .bus_x1(bus_x1), .tx_paused(tx_paused), .led_pin(led_pin)
  );

  task automatic check(input string req, input logic got, input logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, want);
    end
  endtask

  task automatic check_n(input string req, input int got, input int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  function automatic logic [7:0] fld(logic bl, logic iv, logic rt, logic [3:0] md);
    return {bl, iv, rt, 1'b0, md};
  endfunction

  // Write takes effect at the edge; pins follow one edge later.
  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_act(input bit filt);
    @(negedge clk);
    if (filt) act_filt = 1'b1; else act_any = 1'b1;
    @(negedge clk);
    act_filt = 1'b0; act_any = 1'b0;
  endtask

  task automatic measure(input int idx, output int half);
    logic prev;
    int n;
    prev = led_pin[idx];
    n = 0;
    while (led_pin[idx] == prev && n < 3000) begin @(negedge clk); n++; end
    prev = led_pin[idx];
    half = 0;
    while (led_pin[idx] == prev && half < 3000) begin @(negedge clk); half++; end
  endtask

  task automatic t_reset();
    idle(2);
    check("R1 led0 idle", led_pin[0], 1'b1);
    check("R1 led1 idle", led_pin[1], 1'b1);
    link_up = 1'b1; link_speed = 2'd1;
    idle(1);
    check("R1 led0 link", led_pin[0], 1'b0);
    check("R1 led1 link100", led_pin[1], 1'b0);
  endtask

  function automatic logic spd_want(int m, int s, logic up);
    if (!up) return 1'b0;
    case (m)
      0: return (s == 0) || (s == 2);
      1: return (s == 1) || (s == 2);
      2: return 1'b1;
      5: return s == 0;
      6: return s == 1;
      default: return s == 2;
    endcase
  endfunction

  task automatic t_speed();
    int modes[6] = '{0, 1, 2, 5, 6, 7};
    foreach (modes[j]) begin
      wr({8'h06, fld(0, 1, 0, modes[j][3:0])});
      for (int up = 0; up < 2; up++) begin
        for (int s = 0; s < 4; s++) begin
          link_up = up[0]; link_speed = s[1:0];
          idle(1);
          check($sformatf("R2 mode %0d up %0d spd %0d", modes[j], up, s),
                led_pin[0], spd_want(modes[j], s, up[0]));
        end
      end
    end
    link_up = 1'b1; link_speed = 2'd1;
  endtask

  task automatic t_linkact();
    wr({8'h06, fld(0, 1, 0, 4'h4)});
    check("R3 link quiet lit", led_pin[0], 1'b1);
    pulse_act(0);
    check("R3 traffic dark", led_pin[0], 1'b0);
    idle(STR_N + 4);
    check("R3 quiet again lit", led_pin[0], 1'b1);
    link_up = 1'b0; idle(1);
    check("R3 no link dark", led_pin[0], 1'b0);
    link_up = 1'b1; idle(1);
  endtask

  task automatic t_traffic();
    wr({8'h06, fld(0, 1, 0, 4'h3)});
    pulse_act(0);
    check("R4 filtered mode ignores raw", led_pin[0], 1'b0);
    idle(STR_N + 4);
    pulse_act(1);
    check("R4 filtered traffic lit", led_pin[0], 1'b1);
    idle(STR_N + 4);
    wr({8'h06, fld(0, 1, 0, 4'hB)});
    pulse_act(0);
    check("R4 any traffic lit", led_pin[0], 1'b1);
    idle(STR_N + 4);
    link_up = 1'b0;
    pulse_act(0);
    check("R4 traffic without link dark", led_pin[0], 1'b0);
    idle(STR_N + 4);
    link_up = 1'b1;
  endtask

  task automatic t_stretch();
    int n;
    wr({8'h06, fld(0, 1, 0, 4'hA)});
    check("R5 collision idle dark", led_pin[0], 1'b0);
    @(negedge clk); collision = 1'b1;
    @(negedge clk); collision = 1'b0;
    n = 0;
    while (led_pin[0] && n < 1000) begin n++; @(negedge clk); end
    check_n("R8 collision stretch width", n, STR_N);
    wr({8'h06, fld(0, 1, 0, 4'hB)});
    @(negedge clk); act_any = 1'b1;
    @(negedge clk); act_any = 1'b0;
    n = 0;
    while (led_pin[0] && n < 1000) begin n++; @(negedge clk); end
    check_n("R8 traffic stretch width", n, STR_N);
  endtask

  task automatic t_misc();
    wr({8'h06, fld(0, 1, 0, 4'h9)});
    check("R5 half duplex dark", led_pin[0], 1'b0);
    @(negedge clk); full_duplex = 1'b1;
    #1 check("R12 not before edge", led_pin[0], 1'b0);
    @(negedge clk);
    check("R12 R5 full duplex after one edge", led_pin[0], 1'b1);
    wr({8'h06, fld(0, 1, 0, 4'hC)});
    check("R5 multi-lane dark", led_pin[0], 1'b0);
    bus_x1 = 1'b1; idle(1);
    check("R5 single lane lit", led_pin[0], 1'b1);
    wr({8'h06, fld(0, 1, 0, 4'hD)});
    check("R5 not paused dark", led_pin[0], 1'b0);
    tx_paused = 1'b1; idle(1);
    check("R5 paused lit", led_pin[0], 1'b1);
  endtask

  task automatic t_const();
    full_duplex = 1'b1; bus_x1 = 1'b1; tx_paused = 1'b1;
    wr({fld(0, 1, 0, 4'hF), fld(0, 1, 0, 4'h8)});
    check("R6 mode 1000 dark", led_pin[0], 1'b0);
    check("R6 mode 1111 dark", led_pin[1], 1'b0);
    wr({fld(0, 1, 0, 4'hE), fld(0, 0, 0, 4'hE)});
    check("R6 R7 always on active low", led_pin[0], 1'b0);
    check("R6 R7 always on active high", led_pin[1], 1'b1);
    wr({fld(0, 0, 0, 4'hF), fld(0, 0, 0, 4'h8)});
    check("R7 dark active low", led_pin[0], 1'b1);
    check("R7 dark active low led1", led_pin[1], 1'b1);
  endtask

  task automatic t_cfg();
    wr({8'h06, fld(0, 1, 0, 4'hF)});
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {8'h06, 8'h5E};
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 old config one edge after write", led_pin[0], 1'b0);
    @(negedge clk);
    check("R11 new config with reserved bit4 set", led_pin[0], 1'b1);
    wr({8'h5E, 8'h4F});
    check("R11 reserved bit12 ignored", led_pin[1], 1'b1);
  endtask

  task automatic t_blink();
    int h;
    wr({fld(1, 1, 1, 4'hE), fld(1, 1, 0, 4'hE)});
    measure(0, h); check_n("R9 led0 slow half period", h, SLOW_H);
    measure(1, h); check_n("R9 led1 follows led0 rate", h, SLOW_H);
    wr({fld(1, 1, 0, 4'hE), fld(1, 1, 1, 4'hE)});
    measure(0, h); check_n("R9 led0 fast half period", h, FAST_H);
    measure(1, h); check_n("R9 led1 fast via led0 bit", h, FAST_H);
  endtask

  task automatic t_rest();
    int ones;
    int h;
    link_up = 1'b0;
    wr({fld(1, 0, 0, 4'hF), fld(1, 1, 0, 4'h2)});
    ones = 0;
    for (int k = 0; k < 2 * SLOW_H + 10; k++) begin
      @(negedge clk);
      if (led_pin[0]) ones++;
      if (!led_pin[1]) ones++;
    end
    check_n("R10 blinking LEDs rest unlit", ones, 0);
    link_up = 1'b1;
    measure(0, h);
    check_n("R10 blink resumes with condition", h, SLOW_H);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_speed();
    t_linkact();
    t_traffic();
    t_stretch();
    t_misc();
    t_const();
    t_cfg();
    t_blink();
    t_rest();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule